// File: doc/BRIEF.md
# Commit-Gated Store Queue

This block is an in-order queue that sits after address translation in an out-of-order core. Stores, fences and loads that cannot complete at once are entered at the tail in program order, each with the reorder-queue tag of its instruction. The entry at the head leaves first. A store or fence leaves only after its tag has been reported committed. A parked load leaves as soon as it reaches the head, because every older access has drained by then. Stores and loads leave through a single cache request port. Fences leave with no cache access.

A squash indication carries a reorder tag. In that cycle every uncommitted entry whose tag is younger than that tag is discarded, so a discarded speculative store never reaches memory. A combinational lookup port lets a load that is being executed forward data from older pending stores in the same cycle. It also tells the load to park when it cannot be served safely. Depth is a power-of-two parameter: 8 is the small configuration and 64 the large one.

Top module: `commit_store_queue`

## Requirements
- R1: An enqueue is accepted in a cycle when enqValid and enqReady are both high. enqReady is low while the queue holds DEPTH entries, and also in any cycle with squashValid high. Entry kinds are encoded on enqKind as 0 = store, 1 = fence, 2 = load.
- R2: Entries leave strictly in the order they were accepted. A store at the head raises cacheValid with cacheIsWrite=1 and its own address, data, byte mask and tag, but only after a commit with its tag has been seen. The head pops on a cycle with cacheValid and cacheReady both high.
- R3: A committed fence at the head pops in one cycle without raising cacheValid.
- R4: A parked load at the head raises cacheValid with cacheIsWrite=0 without needing a commit.
- R5: With squashValid high, every entry that is not committed and whose tag is younger than squashTag is removed in that cycle and never appears on the cache port. Tag B is younger than tag A when (B - A) modulo 2^TAG_W is nonzero and below 2^(TAG_W-1).
- R6: A lookup whose 8-byte word (address bits above 2) matches older pending stores, with no older fence, forwards from the youngest such store when that store's mask covers the whole load mask. ldHit goes high and ldData holds the store bytes selected by the load mask, with zeros elsewhere.
- R7: When the youngest matching older store does not cover every byte of the load mask, ldPark goes high and ldHit stays low.
- R8: When no older store matches the word, but an older store or parked load is on the same 64-byte line (address bits above 5), ldPark goes high. A different line gives neither ldHit nor ldPark.
- R9: Any older fence still in the queue forces ldPark high and ldHit low.
- R10: Entries whose tags are not older than ldTag are ignored by the lookup.
- R11: While a store request is held with cacheReady low, cacheValid stays high and the address and data stay unchanged.
- R12: After reset the queue is empty: enqReady is high, and cacheValid, ldHit and ldPark are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Enqueue request |
| enqReady | output | 1 | Enqueue can be accepted |
| enqKind | input | 2 | 0 store, 1 fence, 2 load |
| enqTag | input | TAG_W | Reorder tag of the entry |
| enqAddr | input | ADDR_W | Physical byte address |
| enqData | input | DATA_W | Store data |
| enqMask | input | DATA_W/8 | Byte mask |
| commitValid | input | 1 | A reorder entry committed |
| commitTag | input | TAG_W | Tag that committed |
| squashValid | input | 1 | Discard younger speculative work |
| squashTag | input | TAG_W | Entries younger than this tag are discarded |
| ldValid | input | 1 | Lookup request |
| ldTag | input | TAG_W | Tag of the looking-up load |
| ldAddr | input | ADDR_W | Load address |
| ldMask | input | DATA_W/8 | Load byte mask |
| ldHit | output | 1 | Data forwarded this cycle |
| ldPark | output | 1 | Load must be entered into the queue |
| ldData | output | DATA_W | Forwarded data |
| cacheValid | output | 1 | Cache request from the head |
| cacheReady | input | 1 | Cache accepts the request |
| cacheIsWrite | output | 1 | 1 store write, 0 load read |
| cacheAddr | output | ADDR_W | Request address |
| cacheData | output | DATA_W | Write data |
| cacheMask | output | DATA_W/8 | Byte mask |
| cacheTag | output | TAG_W | Reorder tag of the request |

## Verification
The hardest situation to reach is a squash that arrives while committed stores are still waiting at the head for a stalled cache, with uncommitted stores, fences and parked loads behind them that share lines with later lookups. The stimulus reaches it by holding cacheReady low for random stretches. Meanwhile it enqueues from a small pool of addresses on four lines, commits tags in order, and squashes at random points inside the uncommitted window. Lookup tags are drawn from just below the newest tag, so that entries younger than the load are present and must be ignored.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    SQ_STORE = 2'd0,
    SQ_FENCE = 2'd1,
    SQ_LOAD  = 2'd2
  } sqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic enqEn;
    logic deqEn;
    logic killEn;
  } sqStrobe_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enqValid,
  input  logic             squashValid,
  input  logic             cacheReady,
  input  sqKind_e          headKind,
  input  logic             headCommitted,
  input  logic             headKilled,
  input  logic [CNT_W-1:0] killCnt,
  output logic             enqReady,
  output logic             cacheValid,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic [CNT_W-1:0] occupancy,
  output sqStrobe_t        strobe
);
  logic empty, full, headGo;

  assign empty    = (occupancy == '0);
  assign full     = (occupancy == CNT_W'(DEPTH));
  assign enqReady = !full && !squashValid;
  assign headGo   = !empty && !headKilled && (headKind == SQ_LOAD || headCommitted);
  assign cacheValid = headGo && (headKind != SQ_FENCE);

  always_comb begin
    strobe.enqEn  = enqValid && enqReady;
    strobe.deqEn  = headGo && (headKind == SQ_FENCE || cacheReady);
    strobe.killEn = squashValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      occupancy <= '0;
    end else begin
      headPtr   <= headPtr + PTR_W'(strobe.deqEn);
      tailPtr   <= tailPtr + PTR_W'(strobe.enqEn) - PTR_W'(killCnt);
      occupancy <= occupancy + CNT_W'(strobe.enqEn) - CNT_W'(strobe.deqEn) - killCnt;
    end
  end
endmodule

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 6,
  parameter int LINE_LSB = 6,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int MASK_W   = DATA_W / 8,
  localparam int WORD_LSB = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqStrobe_t         strobe,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  sqKind_e           enqKind,
  input  logic [TAG_W-1:0]  enqTag,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [DATA_W-1:0] enqData,
  input  logic [MASK_W-1:0] enqMask,
  input  logic              commitValid,
  input  logic [TAG_W-1:0]  commitTag,
  input  logic [TAG_W-1:0]  squashTag,
  input  logic              ldValid,
  input  logic [TAG_W-1:0]  ldTag,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [MASK_W-1:0] ldMask,
  output sqKind_e           headKind,
  output logic              headCommitted,
  output logic              headKilled,
  output logic [CNT_W-1:0]  killCnt,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic [MASK_W-1:0] headMask,
  output logic [TAG_W-1:0]  headTag,
  output logic              ldHit,
  output logic              ldPark,
  output logic [DATA_W-1:0] ldData
);
  sqKind_e           slotKind [DEPTH];
  logic [TAG_W-1:0]  slotTag  [DEPTH];
  logic [ADDR_W-1:0] slotAddr [DEPTH];
  logic [DATA_W-1:0] slotData [DEPTH];
  logic [MASK_W-1:0] slotMask [DEPTH];
  logic [DEPTH-1:0]  slotValid, slotCommitted, killVec;

  function automatic logic isYounger(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[TAG_W-1];
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_kill
    assign killVec[i] = strobe.killEn && slotValid[i] && !slotCommitted[i] &&
                        isYounger(slotTag[i], squashTag);
  end

  assign killCnt       = CNT_W'($countones(killVec));
  assign headKind      = slotKind[headPtr];
  assign headCommitted = slotCommitted[headPtr];
  assign headKilled    = killVec[headPtr];
  assign headAddr      = slotAddr[headPtr];
  assign headData      = slotData[headPtr];
  assign headMask      = slotMask[headPtr];
  assign headTag       = slotTag[headPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid     <= '0;
      slotCommitted <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (commitValid && slotValid[i] && slotTag[i] == commitTag) slotCommitted[i] <= 1'b1;
        if (killVec[i]) slotValid[i] <= 1'b0;
      end
      if (strobe.deqEn) slotValid[headPtr] <= 1'b0;
      if (strobe.enqEn) begin
        slotValid[tailPtr]     <= 1'b1;
        slotCommitted[tailPtr] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.enqEn) begin
      slotKind[tailPtr] <= enqKind;
      slotTag[tailPtr]  <= enqTag;
      slotAddr[tailPtr] <= enqAddr;
      slotData[tailPtr] <= enqData;
      slotMask[tailPtr] <= enqMask;
    end
  end

  // lookup: walk oldest to youngest so the last match is the youngest
  logic              fwdFound, fwdFull, lineHit, fenceHit;
  logic [DATA_W-1:0] fwdData, byteSel;
  always_comb begin
    logic [PTR_W-1:0] s;
    fwdFound = 1'b0;
    fwdFull  = 1'b0;
    lineHit  = 1'b0;
    fenceHit = 1'b0;
    fwdData  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = headPtr + PTR_W'(k);
      if (slotValid[s] && isYounger(ldTag, slotTag[s])) begin
        if (slotKind[s] == SQ_FENCE) begin
          fenceHit = 1'b1;
        end else if (slotKind[s] == SQ_STORE &&
                     slotAddr[s][ADDR_W-1:WORD_LSB] == ldAddr[ADDR_W-1:WORD_LSB]) begin
          fwdFound = 1'b1;
          fwdFull  = ((slotMask[s] & ldMask) == ldMask);
          fwdData  = slotData[s];
        end else if (slotAddr[s][ADDR_W-1:LINE_LSB] == ldAddr[ADDR_W-1:LINE_LSB]) begin
          lineHit = 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < MASK_W; b++) begin : g_bytes
    assign byteSel[b*8 +: 8] = {8{ldMask[b]}};
  end

  assign ldHit  = ldValid && !fenceHit && fwdFound && fwdFull;
  assign ldPark = ldValid && (fenceHit || (fwdFound && !fwdFull) || (!fwdFound && lineHit));
  assign ldData = ldHit ? (fwdData & byteSel) : '0;
endmodule

// File: rtl/commit_store_queue.sv
module commit_store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 6,
  parameter int LINE_LSB = 6,
  localparam int MASK_W  = DATA_W / 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  output logic              enqReady,
  input  logic [1:0]        enqKind,
  input  logic [TAG_W-1:0]  enqTag,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [DATA_W-1:0] enqData,
  input  logic [MASK_W-1:0] enqMask,
  input  logic              commitValid,
  input  logic [TAG_W-1:0]  commitTag,
  input  logic              squashValid,
  input  logic [TAG_W-1:0]  squashTag,
  input  logic              ldValid,
  input  logic [TAG_W-1:0]  ldTag,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [MASK_W-1:0] ldMask,
  output logic              ldHit,
  output logic              ldPark,
  output logic [DATA_W-1:0] ldData,
  output logic              cacheValid,
  input  logic              cacheReady,
  output logic              cacheIsWrite,
  output logic [ADDR_W-1:0] cacheAddr,
  output logic [DATA_W-1:0] cacheData,
  output logic [MASK_W-1:0] cacheMask,
  output logic [TAG_W-1:0]  cacheTag
);
  sqStrobe_t        strobe;
  sqKind_e          headKind;
  logic             headCommitted, headKilled;
  logic [CNT_W-1:0] killCnt, occupancy;
  logic [PTR_W-1:0] headPtr, tailPtr;

  sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .squashValid(squashValid),
    .cacheReady(cacheReady), .headKind(headKind), .headCommitted(headCommitted),
    .headKilled(headKilled), .killCnt(killCnt), .enqReady(enqReady),
    .cacheValid(cacheValid), .headPtr(headPtr), .tailPtr(tailPtr),
    .occupancy(occupancy), .strobe(strobe)
  );

  sq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
            .LINE_LSB(LINE_LSB)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headPtr(headPtr), .tailPtr(tailPtr),
    .enqKind(sqKind_e'(enqKind)), .enqTag(enqTag), .enqAddr(enqAddr),
    .enqData(enqData), .enqMask(enqMask), .commitValid(commitValid),
    .commitTag(commitTag), .squashTag(squashTag), .ldValid(ldValid), .ldTag(ldTag),
    .ldAddr(ldAddr), .ldMask(ldMask), .headKind(headKind),
    .headCommitted(headCommitted), .headKilled(headKilled), .killCnt(killCnt),
    .headAddr(cacheAddr), .headData(cacheData), .headMask(cacheMask),
    .headTag(cacheTag), .ldHit(ldHit), .ldPark(ldPark), .ldData(ldData)
  );

  assign cacheIsWrite = (headKind == SQ_STORE);
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              enqReady,
  input logic              squashValid,
  input logic              ldHit,
  input logic              ldPark,
  input logic              cacheValid,
  input logic              cacheReady,
  input logic              cacheIsWrite,
  input logic [ADDR_W-1:0] cacheAddr,
  input logic [DATA_W-1:0] cacheData,
  input logic [CNT_W-1:0]  occupancy
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH)); // R1
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    occupancy == CNT_W'(DEPTH) |-> !enqReady); // R1
  AST_SQUASH_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |-> !enqReady); // R1
  AST_HIT_OR_PARK: assert property (@(posedge clk) disable iff (!rstN)
    !(ldHit && ldPark)); // R7
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cacheValid && cacheIsWrite && !cacheReady |=>
      cacheValid && $stable(cacheAddr) && $stable(cacheData)); // R11
endmodule

bind commit_store_queue sq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .enqReady(enqReady), .squashValid(squashValid),
  .ldHit(ldHit), .ldPark(ldPark), .cacheValid(cacheValid), .cacheReady(cacheReady),
  .cacheIsWrite(cacheIsWrite), .cacheAddr(cacheAddr), .cacheData(cacheData),
  .occupancy(occupancy)
);

// File: tb/commit_store_queue_tb.sv
module commit_store_queue_tb;
  localparam int DEPTH = 8;
  localparam int TW = 6;

  logic clk = 0, rstN = 0;
  logic enqValid = 0, commitValid = 0, squashValid = 0, ldValid = 0, cacheReady = 0;
  logic [1:0] enqKind = 0;
  logic [TW-1:0] enqTag = 0, commitTag = 0, squashTag = 0, ldTag = 0;
  logic [31:0] enqAddr = 0, ldAddr = 0;
  logic [63:0] enqData = 0;
  logic [7:0] enqMask = 0, ldMask = 0;
  logic enqReady, ldHit, ldPark, cacheValid, cacheIsWrite;
  logic [63:0] ldData, cacheData;
  logic [31:0] cacheAddr;
  logic [7:0] cacheMask;
  logic [TW-1:0] cacheTag;

  commit_store_queue u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  // model, index 0 is oldest
  logic [1:0] mKind [DEPTH];
  logic [TW-1:0] mTag [DEPTH];
  logic [31:0] mAddr [DEPTH];
  logic [63:0] mData [DEPTH];
  logic [7:0] mMask [DEPTH];
  logic mComm [DEPTH];
  int mN = 0;
  logic [TW-1:0] nextTag = 0, commitNext = 0;
  logic lastAccepted;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic younger(input logic [TW-1:0] a, input logic [TW-1:0] b);
    logic [TW-1:0] d;
    d = a - b;
    return d != 0 && !d[TW-1];
  endfunction

  function automatic logic [63:0] expandMask(input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  // check all outputs against the model, then advance one clock
  task automatic tick();
    logic expReady, go, expCv, deq, eHit, ePark, fFound, fFull, lHit, fHit;
    logic [63:0] fData;
    int nKill;
    #1;
    expReady = (mN < DEPTH) && !squashValid;
    chk(enqReady === expReady, "R1 enqReady", enqReady, expReady);
    nKill = 0;
    if (squashValid)
      for (int i = mN - 1; i >= 0; i--)
        if (!mComm[i] && younger(mTag[i], squashTag)) nKill++;
    go = mN > 0 && !(nKill == mN) && (mKind[0] == 2 || mComm[0]);
    expCv = go && mKind[0] != 1;
    deq = go && (mKind[0] == 1 || cacheReady);
    chk(cacheValid === expCv, "R2/R3/R5 cacheValid", cacheValid, expCv);
    if (expCv) begin
      chk(cacheIsWrite === (mKind[0] == 0), "R2/R4 cacheIsWrite", cacheIsWrite, mKind[0] == 0);
      chk(cacheAddr === mAddr[0] && cacheTag === mTag[0], "R2 head order", cacheAddr, mAddr[0]);
      if (mKind[0] == 0)
        chk(cacheData === mData[0] && cacheMask === mMask[0], "R2 write data", cacheData, mData[0]);
    end
    fFound = 0; fFull = 0; lHit = 0; fHit = 0; fData = 0;
    for (int i = 0; i < mN; i++)
      if (younger(ldTag, mTag[i])) begin  // R10 younger entries skipped
        if (mKind[i] == 1) fHit = 1;
        else if (mKind[i] == 0 && mAddr[i][31:3] == ldAddr[31:3]) begin
          fFound = 1; fFull = (mMask[i] & ldMask) == ldMask; fData = mData[i];
        end else if (mAddr[i][31:6] == ldAddr[31:6]) lHit = 1;
      end
    eHit = ldValid && !fHit && fFound && fFull;
    ePark = ldValid && (fHit || (fFound && !fFull) || (!fFound && lHit));
    chk(ldHit === eHit, "R6/R9/R10 ldHit", ldHit, eHit);
    chk(ldPark === ePark, "R7/R8/R9 ldPark", ldPark, ePark);
    if (eHit) chk(ldData === (fData & expandMask(ldMask)), "R6 ldData", ldData, fData & expandMask(ldMask));
    lastAccepted = enqValid && expReady;
    @(posedge clk);
    if (commitValid) for (int i = 0; i < mN; i++) if (mTag[i] == commitTag) mComm[i] = 1;
    mN -= nKill;
    if (deq) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        mKind[i] = mKind[i+1]; mTag[i] = mTag[i+1]; mAddr[i] = mAddr[i+1];
        mData[i] = mData[i+1]; mMask[i] = mMask[i+1]; mComm[i] = mComm[i+1];
      end
      mN--;
    end
    if (lastAccepted) begin
      mKind[mN] = enqKind; mTag[mN] = enqTag; mAddr[mN] = enqAddr;
      mData[mN] = enqData; mMask[mN] = enqMask; mComm[mN] = 0; mN++;
    end
    @(negedge clk);
    enqValid = 0; commitValid = 0; squashValid = 0; ldValid = 0;
  endtask

  task automatic doEnq(input logic [1:0] k, input logic [31:0] a, input logic [63:0] d, input logic [7:0] m);
    enqValid = 1; enqKind = k; enqTag = nextTag; enqAddr = a; enqData = d; enqMask = m;
    tick();
    if (lastAccepted) nextTag++;
  endtask

  task automatic doCommit();
    commitValid = 1; commitTag = commitNext; commitNext++;
    tick();
  endtask

  task automatic lookupChk(input logic [TW-1:0] t, input logic [31:0] a, input logic [7:0] m,
                           input logic eH, input logic eP, input logic [63:0] eD, input string req);
    ldValid = 1; ldTag = t; ldAddr = a; ldMask = m;
    #1;
    chk(ldHit === eH && ldPark === eP, req, {ldHit, ldPark}, {eH, eP});
    if (eH) chk(ldData === eD, req, ldData, eD);
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk(enqReady === 1 && cacheValid === 0 && ldHit === 0 && ldPark === 0, "R12 reset state",
        {enqReady, cacheValid, ldHit, ldPark}, 4'b1000);
    // directed corner cases
    cacheReady = 0;
    doEnq(0, 32'h100, 64'h1111_2222_3333_4444, 8'hFF);          // tag0
    doEnq(0, 32'h100, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);          // tag1
    lookupChk(2, 32'h100, 8'h0F, 1, 0, 64'h0000_0000_CCCC_DDDD, "R6 youngest older store");
    lookupChk(2, 32'h100, 8'hF0, 0, 1, 0, "R7 partial cover parks");
    lookupChk(1, 32'h104, 8'hF0, 1, 0, 64'h1111_2222_0000_0000, "R10 younger store ignored");
    lookupChk(2, 32'h108, 8'hFF, 0, 1, 0, "R8 same line parks");
    lookupChk(2, 32'h140, 8'hFF, 0, 0, 0, "R8 other line free");
    chk(cacheValid === 0, "R2 uncommitted store held", cacheValid, 0);
    doCommit();                                                   // commit tag0
    #1 chk(cacheValid === 1 && cacheAddr === 32'h100 && cacheIsWrite === 1, "R2 committed drains",
           cacheAddr, 32'h100);
    doEnq(1, 0, 0, 0);                                            // fence tag2
    lookupChk(3, 32'h400, 8'hFF, 0, 1, 0, "R9 fence parks");
    squashValid = 1; squashTag = 0;                               // drop tag1, fence
    #1 chk(enqReady === 0, "R1 squash stalls enqueue", enqReady, 0);
    tick();
    nextTag = 1;
    cacheReady = 1;
    tick();
    #1 chk(cacheValid === 0, "R5 squashed never written", cacheValid, 0);
    doEnq(2, 32'h200, 0, 8'hFF);                                  // parked load tag1
    #1 chk(cacheValid === 1 && cacheIsWrite === 0, "R4 load reads uncommitted", cacheIsWrite, 0);
    tick();
    commitNext = 2;
    // fill to full
    cacheReady = 0;
    for (int i = 0; i < DEPTH; i++) doEnq(0, 32'h300 + 32'(i * 8), 64'(i), 8'hFF);
    #1 chk(enqReady === 0, "R1 full stalls", enqReady, 0);
    for (int i = 0; i < DEPTH; i++) doCommit();
    cacheReady = 1;
    doEnq(1, 0, 0, 0);                                            // fence behind stores
    doCommit();
    repeat (12) tick();
    #1 chk(cacheValid === 0 && enqReady === 1, "R3 fence left without access", cacheValid, 0);
    // random phase
    for (int c = 0; c < 5000; c++) begin
      int r;
      cacheReady = ($urandom % 3) != 0;
      r = $urandom % 10;
      if (r < 4 && TW'(nextTag - commitNext) < 12) begin
        int kr;
        kr = $urandom % 20;
        enqValid = 1; enqKind = kr < 12 ? 2'd0 : (kr < 17 ? 2'd2 : 2'd1);
        enqTag = nextTag; enqAddr = 32'(($urandom % 4) * 64 + ($urandom % 8) * 8);
        enqData = {$urandom, $urandom};
        enqMask = ($urandom % 2) ? 8'hFF : 8'($urandom);
      end else if (r < 7 && commitNext != nextTag) begin
        commitValid = 1; commitTag = commitNext;
      end else if (r == 7) begin
        squashValid = 1;
        squashTag = commitNext - 1 + TW'($urandom % (TW'(nextTag - commitNext) + 1));
      end
      if ($urandom % 2) begin
        ldValid = 1; ldTag = nextTag - TW'($urandom % 4);
        ldAddr = 32'(($urandom % 4) * 64 + ($urandom % 8) * 8);
        ldMask = ($urandom % 2) ? 8'hFF : 8'($urandom);
      end
      begin
        logic wasC, wasS;
        logic [TW-1:0] st;
        wasC = commitValid; wasS = squashValid; st = squashTag;
        tick();
        if (lastAccepted) nextTag++;
        if (wasC) commitNext++;
        if (wasS) nextTag = st + 1;
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule